// File: doc/BRIEF.md
# Decade-Prescaled Pacer Timer

This block paces periodic updates. A free-running time base delivers a one-cycle tick once every microsecond. A decade prescaler divides those ticks by one of seven powers of ten, from 1 to 1,000,000. An 8-bit down-counter then counts the prescaled periods. The update interval is therefore the prescaler period times the 8-bit count. With a 1 s prescaler period and the full count of 256, the interval comes to roughly 4.27 minutes.

Loading a count starts a new pacing sequence at once. The block issues an update strobe right away, restarts the prescaler from zero and begins counting down. When the count runs out, it reloads the stored value and strobes again. After every update a second output raises a clock pulse one prescaler period later and holds it for one prescaler period. An enable input freezes the whole block. A status output shows how many prescaler periods remain before the next update.

Top module: `pacer_timer`

## Requirements
- R1: For `rate_sel` values 0 to 6, one prescaler period lasts 10^`rate_sel` ticks of `tick_us`.
- R2: The reserved value `rate_sel` = 7 gives a prescaler period of one tick, the same as value 0.
- R3: Consecutive update strobes are P×N ticks apart, where P is the prescaler period and N is `period_cnt`. A `period_cnt` of 0 stands for N = 256.
- R4: A `load` sampled while `enable` is high makes `update_stb` high for the single cycle after that edge. In that same cycle `remaining` shows N.
- R5: A load clears the prescaler. A tick sampled on the load edge is ignored, so the first strobe after a load comes exactly P×N ticks later.
- R6: When `remaining` runs out, the stored N is reloaded and strobing continues without further loads.
- R7: `clk_pulse` rises P ticks after each update and falls 2P ticks after it. Both edges show in the cycle after the tick that causes them.
- R8: An update always forces `clk_pulse` low. With N = 1 the pulse is therefore never raised, and `clk_pulse` is never high in a cycle where `update_stb` is high.
- R9: While `enable` is low, no strobe is issued, `clk_pulse` is low and `remaining` holds its value.
- R10: A `load` while `enable` is low stores N and shows it on `remaining`, but issues no strobe.
- R11: After reset, `update_stb` and `clk_pulse` are low and `remaining` is 0 until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle time-base tick, 1 µs apart |
| enable | input | 1 | Run (1) or freeze (0) |
| rate_sel | input | 3 | Decade prescaler select |
| period_cnt | input | 8 | Prescaler periods per update, 0 means 256 |
| load | input | 1 | Store `period_cnt` and restart pacing |
| update_stb | output | 1 | One-cycle update strobe |
| clk_pulse | output | 1 | Delayed output clock pulse |
| remaining | output | 9 | Prescaler periods left before the next update |

## Verification
Every result is registered exactly once. The load strobe and the reloaded `remaining` appear in the cycle right after the load edge. Periodic strobes and both edges of `clk_pulse` appear in the cycle after the tick edge that completes their period. The bench therefore measures in ticks rather than in clock cycles. A monitor samples two time units after each rising edge, counts the ticks consumed on that edge, and notes the tick count at which the pulse rises, the count at which it falls, and the count at which the next strobe arrives. Those counts are compared with P, 2P and P×N, independent of the phase at which a load arrives. Checks on the strobe and the status right after a load are taken at the following falling edge.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // number of decade steps offered by the prescaler select
  localparam int unsigned NUM_DECADES = 7;
  localparam int unsigned SEL_W       = 3;
  localparam int unsigned CNT_W       = 8;

  // ten raised to the given exponent
  function automatic int unsigned decade(input int unsigned e);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

  // width needed for a divider that reaches the largest decade
  localparam int unsigned PRE_W = $clog2(decade(NUM_DECADES - 1));

endpackage

// File: rtl/pacer_prescaler.sv
module pacer_prescaler
  import pacer_pkg::*;
#(
  parameter int unsigned N_SEL = NUM_DECADES,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned PW    = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          restart,
  input  logic [SW-1:0] sel,
  output logic          pre_tick
);

  localparam int unsigned TAB_N = 1 << SW;

  // terminal value of the divider for every select code
  logic [PW-1:0] lim_tab [TAB_N];
  logic [PW-1:0] lim;
  logic [PW-1:0] div_q, div_d;
  logic          at_end;

  genvar g;
  generate
    for (g = 0; g < TAB_N; g++) begin : g_lim
      if (g < N_SEL) begin : g_dec
        assign lim_tab[g] = PW'(decade(g) - 1);
      end else begin : g_rsv
        assign lim_tab[g] = '0;
      end
    end
  endgenerate

  assign lim      = lim_tab[sel];
  assign at_end   = (div_q >= lim);
  assign pre_tick = run && tick && !restart && at_end;

  always_comb begin
    div_d = div_q;
    if (restart) begin
      div_d = '0;
    end else if (run && tick) begin
      if (at_end) div_d = '0;
      else        div_d = div_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/pacer_downcnt.sv
module pacer_downcnt
  import pacer_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          pre_tick,
  output logic          fire,
  output logic [CW:0]   remain
);

  logic [CW:0] reload_q, reload_d;
  logic [CW:0] rem_q, rem_d;
  logic [CW:0] load_full;
  logic        expire;

  // zero stands for the full range
  assign load_full = (load_val == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, load_val};
  assign expire    = run && pre_tick && !load && (rem_q == (CW+1)'(1));
  assign fire      = (load && run) || expire;
  assign remain    = rem_q;

  always_comb begin
    reload_d = reload_q;
    rem_d    = rem_q;
    if (load) begin
      reload_d = load_full;
      rem_d    = load_full;
    end else if (expire) begin
      rem_d    = reload_q;
    end else if (run && pre_tick && (rem_q != '0)) begin
      rem_d    = rem_q - (CW+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      rem_q    <= '0;
    end else begin
      reload_q <= reload_d;
      rem_q    <= rem_d;
    end
  end

endmodule

// File: rtl/pacer_outclk.sv
module pacer_outclk (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fire,
  input  logic pre_tick,
  output logic pulse
);

  logic armed_q, armed_d;
  logic pulse_q, pulse_d;

  always_comb begin
    armed_d = armed_q;
    pulse_d = pulse_q;
    if (!run) begin
      armed_d = 1'b0;
      pulse_d = 1'b0;
    end else if (fire) begin
      armed_d = 1'b1;
      pulse_d = 1'b0;
    end else if (pre_tick) begin
      if (armed_q) begin
        armed_d = 1'b0;
        pulse_d = 1'b1;
      end else if (pulse_q) begin
        pulse_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/pacer_timer.sv
module pacer_timer
  import pacer_pkg::*;
#(
  parameter int unsigned N_SEL = NUM_DECADES,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned CW    = CNT_W,
  parameter int unsigned PW    = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic          enable,
  input  logic [SW-1:0] rate_sel,
  input  logic [CW-1:0] period_cnt,
  input  logic          load,
  output logic          update_stb,
  output logic          clk_pulse,
  output logic [CW:0]   remaining
);

  logic pre_tick;
  logic fire;
  logic stb_q, stb_d;

  pacer_prescaler #(.N_SEL(N_SEL), .SW(SW), .PW(PW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_us),
    .run      (enable),
    .restart  (load),
    .sel      (rate_sel),
    .pre_tick (pre_tick)
  );

  pacer_downcnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable),
    .load     (load),
    .load_val (period_cnt),
    .pre_tick (pre_tick),
    .fire     (fire),
    .remain   (remaining)
  );

  pacer_outclk u_oclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable),
    .fire     (fire),
    .pre_tick (pre_tick),
    .pulse    (clk_pulse)
  );

  assign stb_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign update_stb = stb_q;

endmodule

// File: rtl/pacer_timer_chk.sv
module pacer_timer_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          load,
  input logic [CW-1:0] period_cnt,
  input logic          update_stb,
  input logic          clk_pulse,
  input logic [CW:0]   remaining
);

  // R4
  load_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && enable) |=> update_stb);

  // R4
  load_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (remaining == (($past(period_cnt) == '0) ? (CW+1)'(1 << CW)
                                                     : {1'b0, $past(period_cnt)})));

  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !update_stb);

  // R9
  idle_pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !clk_pulse);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(enable) && !$past(load)) |-> $stable(remaining));

  // R8
  pulse_vs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_stb |-> !clk_pulse);

endmodule

bind pacer_timer pacer_timer_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .load       (load),
  .period_cnt (period_cnt),
  .update_stb (update_stb),
  .clk_pulse  (clk_pulse),
  .remaining  (remaining)
);

// File: tb/pacer_timer_bench.sv
module pacer_timer_bench;

  logic       clk;
  logic       rst_n;
  logic       tick_us;
  logic       enable;
  logic [2:0] rate_sel;
  logic [7:0] period_cnt;
  logic       load;
  logic       update_stb;
  logic       clk_pulse;
  logic [8:0] remaining;

  int total = 0;
  int bad   = 0;

  // monitor state, measured in ticks since the last strobe
  int tcnt = 0, rise_at = -1, fall_at = -1, nstrobe = 0;
  int iv = 0, rv = -1, fv = -1;
  logic prev_pulse = 1'b0;

  pacer_timer u_pacer_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_us    (tick_us),
    .enable     (enable),
    .rate_sel   (rate_sel),
    .period_cnt (period_cnt),
    .load       (load),
    .update_stb (update_stb),
    .clk_pulse  (clk_pulse),
    .remaining  (remaining)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // time base: one tick every four clocks
  initial begin
    tick_us = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick_us = 1'b1;
      @(negedge clk);
      tick_us = 1'b0;
    end
  end

  // monitor: the tick count is incremented before the strobe closes an interval
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst_n) begin
        tcnt = 0; rise_at = -1; fall_at = -1; prev_pulse = 1'b0;
      end else begin
        if (tick_us) tcnt++;
        if (clk_pulse && !prev_pulse) rise_at = tcnt;
        if (!clk_pulse && prev_pulse) fall_at = tcnt;
        prev_pulse = clk_pulse;
        if (update_stb) begin
          iv = tcnt; rv = rise_at; fv = fall_at;
          nstrobe++;
          tcnt = 0; rise_at = -1; fall_at = -1;
        end
      end
    end
  end

  function automatic int dec_p(input int s);
    int r;
    r = 1;
    if (s < 7) for (int i = 0; i < s; i++) r = r * 10;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int s, input int v);
    @(negedge clk);
    rate_sel   = 3'(s);
    period_cnt = 8'(v);
    load       = 1'b1;
    @(negedge clk);
    load       = 1'b0;
  endtask

  task automatic wait_strobes(input int target);
    while (nstrobe < target) @(posedge clk);
    #3;
  endtask

  // {rate_sel, period_cnt}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'd1}, {3'd0, 8'd3}, {3'd1, 8'd2}, {3'd2, 8'd3},
    {3'd7, 8'd4}, {3'd0, 8'd0}, {3'd3, 8'd2}, {3'd1, 8'd1}
  };

  initial begin
    #1900000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, p, n, hold, sb;
    rst_n = 1'b0; enable = 1'b0; rate_sel = '0; period_cnt = '0; load = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 stb in reset", int'(update_stb), 0);
    check("R11 pulse in reset", int'(clk_pulse), 0);
    check("R11 remaining in reset", int'(remaining), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    repeat (40) @(negedge clk);
    check("R11 no strobe before load", nstrobe, 0);
    check("R11 remaining before load", int'(remaining), 0);

    foreach (VEC[i]) begin
      p = dec_p(int'(VEC[i][10:8]));
      n = (VEC[i][7:0] == 8'd0) ? 256 : int'(VEC[i][7:0]);
      do_load(int'(VEC[i][10:8]), int'(VEC[i][7:0]));
      // R4 strobe and status in the cycle after the load edge
      check("R4 load strobe", int'(update_stb), 1);
      check("R4 status after load", int'(remaining), n);
      base = nstrobe;
      wait_strobes(base + 1);
      // R5 first interval exact; R1 R2 R3 period product
      check("R5 R3 first interval", iv, p * n);
      check(n == 1 ? "R8 no pulse" : "R7 pulse rise", rv, n == 1 ? -1 : p);
      wait_strobes(base + 2);
      // R6 free running reload
      check("R6 R1 R2 second interval", iv, p * n);
      check(n == 1 ? "R8 no pulse again" : "R7 pulse fall", fv, n == 1 ? -1 : 2 * p);
    end

    // R9 freeze while disabled
    do_load(1, 3);
    repeat (50) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    hold = int'(remaining);
    sb = nstrobe;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (clk_pulse || int'(remaining) != hold) begin
        total++; bad++;
        $display("FAIL R9 frozen actual=%0d/%0d expected=0/%0d", clk_pulse, remaining, hold);
      end
    end
    check("R9 no strobe while disabled", nstrobe, sb);
    check("R9 status held", int'(remaining), hold);

    // R10 load while disabled
    do_load(0, 5);
    check("R10 no strobe on idle load", int'(update_stb), 0);
    check("R10 value stored", int'(remaining), 5);
    repeat (30) @(negedge clk);
    check("R10 still no strobe", nstrobe, sb);
    enable = 1'b1;
    wait_strobes(sb + 2);
    check("R10 R6 interval after enable", iv, 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule